// File: doc/BRIEF.md
# Message Interrupt Pending and Select Unit

This unit sits inside one processor core and collects up to 256 numbered message interrupts. Each message that reaches the core arrives as a one-cycle valid strobe with an 8-bit number, and the unit records it in a 256-bit pending record. Software reads that record as four 64-bit status words, chosen by a word-select input. A software-written threshold decides which pending numbers may be chosen. Among those, the unit picks the highest number, because a larger number always has higher priority.

The chosen number is held in a result register together with an empty flag. A core-level message status bit is also raised. The interrupt request toward the core is that status bit gated by the global interrupt enable, and no other mask applies. A software read of the result register acknowledges the interrupt: it clears the pending bit of the number currently held. The result register, the empty flag and the status bit follow the pending record one clock later.

The unit also computes the common entry offset used by every message interrupt, from the vector-spacing field. It also reports whether the core takes the message request or a line interrupt request, with the message request winning when both are present.

Top module: `msgint_unit`

## Requirements
- R1: After reset all 256 pending bits are 0, the threshold is 0, the number field reads 0, res_empty is 1, msg_stat is 0 and msg_req is 0.
- R2: A cycle with msg_valid high and msg_id = n sets pending bit n at that clock edge. Status word k (word_sel = k) presents numbers 64k to 64k+63, with number 64k+j on bit j.
- R3: One clock after the pending record or the threshold changes, res_num holds the highest pending number that is greater than or equal to the threshold. Number 255 is highest and number 0 is lowest. When nothing is eligible, res_num reads 0.
- R4: A pending number below the threshold is never selected. If no pending number reaches the threshold, res_empty is 1 and msg_stat is 0.
- R5: When an eligible number exists, res_empty is 0 and msg_stat is 1. res_empty is always the inverse of msg_stat.
- R6: msg_req is 1 exactly when msg_stat is 1 and gie is 1. msg_stat itself does not depend on gie.
- R7: A cycle with res_rd high while msg_stat is 1 clears the pending bit of the number in res_num. A cycle with res_rd high while msg_stat is 0 changes no pending bit.
- R8: If no eligible pending number remains after a read clears a bit, then on the next clock msg_stat goes to 0 and res_empty goes to 1.
- R9: take_msg equals msg_req. take_line is 1 only when line_req is 1 and msg_req is 0.
- R10: entry_off equals 0x4E shifted left by vs+2. Over the 3-bit vs range this gives 0x138 up to 0x9C00.
- R11: If msg_valid sets number n in the same cycle that a read clears n, bit n stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An incoming message is present this cycle |
| msg_id | input | 8 | Number of the incoming message |
| thr_we | input | 1 | Write strobe for the threshold |
| thr_val | input | 8 | New threshold value |
| res_rd | input | 1 | Software read of the result register (acknowledge) |
| word_sel | input | 2 | Selects which 64-bit status word is presented |
| gie | input | 1 | Global interrupt enable |
| line_req | input | 1 | Line interrupt request from the line controller |
| vs | input | 3 | Vector-spacing configuration field |
| word_data | output | 64 | Selected status word of the pending record |
| res_num | output | 8 | Number held in the result register |
| res_empty | output | 1 | Result register holds no valid number |
| msg_stat | output | 1 | Core message-interrupt status bit |
| msg_req | output | 1 | Message request after the global enable |
| take_msg | output | 1 | Core takes the message request |
| take_line | output | 1 | Core takes the line request |
| entry_off | output | 16 | In-page entry offset for all message interrupts |

## Verification
The hardest situation to reach is a read that clears a number while the same number arrives again in that cycle. The one-cycle lag of the result register makes the timing narrow. The bench watches res_num at the falling edge and drives the read and the message for that exact number on the next cycle. It also steers the random message numbers toward the currently held number, so collisions recur. A second hard case is a threshold that moves while interrupts are pending. Random threshold writes land between arrivals and reads, and the bench's model predicts the selection that follows.

// File: rtl/msgint_pkg.sv
// Package: msgint_pkg
// Shared defaults and types for the message interrupt unit.
// Assumes the number space is a whole multiple of the status word width.
package msgint_pkg;
    localparam int MSG_IDS_DEF  = 256;
    localparam int WORD_W_DEF   = 64;
    localparam int VS_W_DEF     = 3;
    localparam int ENTRY_CODE   = 8'h4E;
    localparam int ENTRY_CODE_W = 7;

    // Which request the core takes this cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MSG  = 2'd1,
        SRC_LINE = 2'd2
    } irq_src_e;
endpackage

// File: rtl/msgint_pend_store.sv
// Module: msgint_pend_store
// Holds one pending bit per message number. A set and a clear can hit
// the same bit in one cycle, and the set wins.
// Assumes set_id and clr_id are in range when their enables are high.
module msgint_pend_store #(
    parameter int N    = 256,
    localparam int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [ID_W-1:0] set_id,
    input  logic            clr_en,
    input  logic [ID_W-1:0] clr_id,
    output logic [N-1:0]    pend_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit update: reset, then set over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[i] <= 1'b0;
            else if (set_en && (set_id == ID_W'(i)))
                pend_q[i] <= 1'b1;
            else if (clr_en && (clr_id == ID_W'(i)))
                pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/msgint_prio_pick.sv
// Module: msgint_prio_pick
// Combinational selection: the highest pending number at or above the
// threshold. Gives found = 0 and id = 0 when nothing is eligible.
// Assumes the threshold is compared as an unsigned number.
module msgint_prio_pick #(
    parameter int N    = 256,
    localparam int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    pend,
    input  logic [ID_W-1:0] thresh,
    output logic            found,
    output logic [ID_W-1:0] id
);
    logic [N-1:0] elig;

    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = pend[i] && (ID_W'(i) >= thresh);
    end

    // Scan upward; a later (higher) eligible number overrides
    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                found = 1'b1;
                id    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/msgint_result.sv
// Module: msgint_result
// Result register: holds the chosen number, the empty flag and the
// status bit. It loads every cycle from the selection of the previous
// state, so it trails the pending record by one clock.
module msgint_result #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            found,
    input  logic [ID_W-1:0] id,
    output logic [ID_W-1:0] num_q,
    output logic            empty_q,
    output logic            stat_q
);
    // Capture the selection; empty and status are complementary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q   <= '0;
            empty_q <= 1'b1;
            stat_q  <= 1'b0;
        end else begin
            num_q   <= found ? id : '0;
            empty_q <= !found;
            stat_q  <= found;
        end
    end
endmodule

// File: rtl/msgint_unit.sv
// Module: msgint_unit
// Per-core message interrupt pending and select unit. It records incoming
// messages, picks the highest eligible number, publishes it, and clears
// it on a read of the result register. It also computes the common entry
// offset and the message-over-line choice.
// Assumes one message at most per cycle and a single-cycle read strobe.
module msgint_unit
    import msgint_pkg::*;
#(
    parameter int MSG_IDS = MSG_IDS_DEF,
    parameter int WORD_W  = WORD_W_DEF,
    parameter int VS_W    = VS_W_DEF,
    localparam int ID_W   = $clog2(MSG_IDS),
    localparam int NWORDS = MSG_IDS / WORD_W,
    localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int OFF_W  = ENTRY_CODE_W + (1 << VS_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [ID_W-1:0]   msg_id,
    input  logic              thr_we,
    input  logic [ID_W-1:0]   thr_val,
    input  logic              res_rd,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic              gie,
    input  logic              line_req,
    input  logic [VS_W-1:0]   vs,
    output logic [WORD_W-1:0] word_data,
    output logic [ID_W-1:0]   res_num,
    output logic              res_empty,
    output logic              msg_stat,
    output logic              msg_req,
    output logic              take_msg,
    output logic              take_line,
    output logic [OFF_W-1:0]  entry_off
);
    logic [MSG_IDS-1:0] pend_q;
    logic [ID_W-1:0]    thr_q;
    logic               pick_found;
    logic [ID_W-1:0]    pick_id;
    logic               ack;
    irq_src_e           src;

    // A read only acknowledges while a number is published
    assign ack = res_rd && msg_stat;

    // Threshold register written by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_q <= '0;
        else if (thr_we)
            thr_q <= thr_val;
    end

    msgint_pend_store #(.N(MSG_IDS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (msg_valid),
        .set_id (msg_id),
        .clr_en (ack),
        .clr_id (res_num),
        .pend_q (pend_q)
    );

    msgint_prio_pick #(.N(MSG_IDS)) u_pick (
        .pend   (pend_q),
        .thresh (thr_q),
        .found  (pick_found),
        .id     (pick_id)
    );

    msgint_result #(.ID_W(ID_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .found   (pick_found),
        .id      (pick_id),
        .num_q   (res_num),
        .empty_q (res_empty),
        .stat_q  (msg_stat)
    );

    // Status word view of the pending record
    always_comb begin
        word_data = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (word_sel == SEL_W'(k))
                word_data = pend_q[k*WORD_W +: WORD_W];
        end
    end

    // Global enable is the only mask on the request
    assign msg_req = msg_stat && gie;

    // Message request outranks the line request
    always_comb begin
        if (msg_req)       src = SRC_MSG;
        else if (line_req) src = SRC_LINE;
        else               src = SRC_NONE;
    end
    assign take_msg  = (src == SRC_MSG);
    assign take_line = (src == SRC_LINE);

    // Uniform entry offset: code scaled by the vector spacing
    assign entry_off = OFF_W'(ENTRY_CODE) << (int'(vs) + 2);
endmodule

// File: rtl/msgint_unit_chk.sv
// Module: msgint_unit_chk
// Assertion checker for msgint_unit, attached by bind below.
module msgint_unit_chk #(
    parameter int MSG_IDS = 256,
    localparam int ID_W   = $clog2(MSG_IDS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic [ID_W-1:0]    msg_id,
    input logic               res_rd,
    input logic               gie,
    input logic [ID_W-1:0]    res_num,
    input logic               res_empty,
    input logic               msg_stat,
    input logic               msg_req,
    input logic               take_msg,
    input logic               take_line,
    input logic [MSG_IDS-1:0] pend_q,
    input logic [ID_W-1:0]    thr_q
);
    AST_ARRIVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> pend_q[$past(msg_id)]); // R2

    AST_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_stat && $stable(thr_q)) |-> (res_num >= thr_q)); // R4

    AST_STAT_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        msg_stat |-> !res_empty); // R5

    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !msg_req); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && msg_stat && !(msg_valid && (msg_id == res_num)))
        |=> !pend_q[$past(res_num)]); // R7

    AST_MSG_OVER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (take_msg && !take_line)); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_rd && msg_stat && msg_valid && (msg_id == res_num))
        |=> pend_q[$past(res_num)]); // R11
endmodule

bind msgint_unit msgint_unit_chk #(.MSG_IDS(MSG_IDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_id    (msg_id),
    .res_rd    (res_rd),
    .gie       (gie),
    .res_num   (res_num),
    .res_empty (res_empty),
    .msg_stat  (msg_stat),
    .msg_req   (msg_req),
    .take_msg  (take_msg),
    .take_line (take_line),
    .pend_q    (pend_q),
    .thr_q     (thr_q)
);

// File: tb/tb_msgint_unit.sv
// Bench for msgint_unit: directed corner cases plus seeded random traffic,
// checked against a bench-side model of the pending record and result.
module tb_msgint_unit;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_id = '0;
    logic        thr_we = 1'b0;
    logic [7:0]  thr_val = '0;
    logic        res_rd = 1'b0;
    logic [1:0]  word_sel = '0;
    logic        gie = 1'b0;
    logic        line_req = 1'b0;
    logic [2:0]  vs = '0;
    logic [63:0] word_data;
    logic [7:0]  res_num;
    logic        res_empty, msg_stat, msg_req, take_msg, take_line;
    logic [15:0] entry_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [255:0] m_pend = '0;
    logic [7:0]   m_thr  = '0;
    logic         m_stat = 1'b0;
    logic [7:0]   m_num  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msgint_unit dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
        .thr_we(thr_we), .thr_val(thr_val), .res_rd(res_rd),
        .word_sel(word_sel), .gie(gie), .line_req(line_req), .vs(vs),
        .word_data(word_data), .res_num(res_num), .res_empty(res_empty),
        .msg_stat(msg_stat), .msg_req(msg_req), .take_msg(take_msg),
        .take_line(take_line), .entry_off(entry_off)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model of the selection: highest pending number at or above threshold
    function automatic void pick(input logic [255:0] p, input logic [7:0] t,
                                 output logic f, output logic [7:0] id);
        f = 1'b0; id = '0;
        for (int i = 0; i < 256; i++)
            if (p[i] && (i >= int'(t))) begin f = 1'b1; id = 8'(i); end
    endfunction

    // Compare every output against the model (called at a falling edge)
    task automatic compare_all();
        logic [15:0] off;
        off = 16'(32'h4E << (int'(vs) + 2));
        chk("R3 res_num", 64'(res_num), 64'(m_num));
        chk("R8 res_empty", 64'(res_empty), 64'(!m_stat));
        chk("R5 msg_stat", 64'(msg_stat), 64'(m_stat));
        chk("R6 msg_req", 64'(msg_req), 64'(m_stat && gie));
        chk("R9 take_msg", 64'(take_msg), 64'(m_stat && gie));
        chk("R9 take_line", 64'(take_line), 64'(line_req && !(m_stat && gie)));
        chk("R2 word_data", word_data, m_pend[int'(word_sel)*64 +: 64]);
        chk("R10 entry_off", 64'(entry_off), 64'(off));
    endtask

    // One clock with the given strobes; updates the model as the design should
    task automatic cyc(input logic v, input logic [7:0] n, input logic rd,
                       input logic twe, input logic [7:0] tv);
        logic f;
        logic [7:0] id;
        msg_valid = v; msg_id = n; res_rd = rd; thr_we = twe; thr_val = tv;
        @(posedge clk);
        pick(m_pend, m_thr, f, id);
        if (rd && m_stat) m_pend[m_num] = 1'b0;
        if (v) m_pend[n] = 1'b1;
        if (twe) m_thr = tv;
        m_stat = f;
        m_num  = f ? id : 8'd0;
        @(negedge clk);
        msg_valid = 1'b0; res_rd = 1'b0; thr_we = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(1'b0, 8'd0, 1'b0, 1'b0, 8'd0);
    endtask

    initial begin
        void'($urandom(32'd20240411));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 res_empty", 64'(res_empty), 64'd1);
        chk("R1 msg_stat", 64'(msg_stat), 64'd0);
        chk("R1 res_num", 64'(res_num), 64'd0);
        chk("R1 msg_req", 64'(msg_req), 64'd0);
        for (int k = 0; k < 4; k++) begin
            word_sel = 2'(k); #1;
            chk("R1 word", word_data, 64'd0);
        end
        word_sel = 2'd0;
        gie = 1'b1;

        // R2/R3: single message, then the boundaries 0 and 255
        cyc(1'b1, 8'd5, 1'b0, 1'b0, 8'd0);
        idle(1);
        chk("R3 single", 64'(res_num), 64'd5);
        cyc(1'b1, 8'd0, 1'b0, 1'b0, 8'd0);
        cyc(1'b1, 8'd255, 1'b0, 1'b0, 8'd0);
        idle(1);
        chk("R3 top wins", 64'(res_num), 64'd255);
        word_sel = 2'd3; #1;
        chk("R2 word3 bit63", 64'(word_data[63]), 64'd1);
        word_sel = 2'd0; #1;
        chk("R2 word0 bits", 64'(word_data[5:0]), 64'h21);

        // R7/R8: drain by reads, highest first
        cyc(1'b0, 8'd0, 1'b1, 1'b0, 8'd0);
        word_sel = 2'd3; #1;
        chk("R7 cleared 255", 64'(word_data[63]), 64'd0);
        idle(1);
        chk("R7 next is 5", 64'(res_num), 64'd5);
        cyc(1'b0, 8'd0, 1'b1, 1'b0, 8'd0);
        idle(1);
        cyc(1'b0, 8'd0, 1'b1, 1'b0, 8'd0);
        chk("R8 still set one cycle", 64'(msg_stat), 64'd1);
        idle(1);
        chk("R8 empty after drain", 64'(res_empty), 64'd1);
        chk("R8 stat low", 64'(msg_stat), 64'd0);
        // R7: read while empty changes nothing
        cyc(1'b1, 8'd70, 1'b1, 1'b0, 8'd0);
        word_sel = 2'd1; #1;
        chk("R7 read while idle", 64'(word_data[6]), 64'd1);

        // R4: threshold above the only pending number
        cyc(1'b0, 8'd0, 1'b0, 1'b1, 8'd100);
        idle(1);
        chk("R4 below threshold", 64'(res_empty), 64'd1);
        cyc(1'b1, 8'd100, 1'b0, 1'b0, 8'd0);
        idle(1);
        chk("R4 equal threshold eligible", 64'(res_num), 64'd100);

        // R11: set and clear of the same number in one cycle
        cyc(1'b1, 8'd100, 1'b1, 1'b0, 8'd0);
        idle(1);
        chk("R11 set wins", 64'(res_num), 64'd100);
        chk("R11 still pending", 64'(msg_stat), 64'd1);

        // R6/R9: enable and line request combinations
        gie = 1'b0; line_req = 1'b1; #1;
        chk("R6 masked req", 64'(msg_req), 64'd0);
        chk("R6 stat unmasked", 64'(msg_stat), 64'd1);
        chk("R9 line when masked", 64'(take_line), 64'd1);
        gie = 1'b1; #1;
        chk("R9 msg over line", 64'(take_line), 64'd0);

        // R10: sweep the vector spacing
        for (int v = 0; v < 8; v++) begin
            vs = 3'(v); #1;
            chk("R10 offset", 64'(entry_off), 64'(32'h4E << (v + 2)));
        end
        cyc(1'b0, 8'd0, 1'b0, 1'b1, 8'd0);

        // Random traffic, ids biased toward the held number
        for (int i = 0; i < N_RAND; i++) begin
            logic v, rd, twe;
            logic [7:0] n, tv;
            v   = ($urandom % 3) == 0;
            n   = (($urandom % 4) == 0) ? res_num : 8'($urandom);
            rd  = ($urandom % 4) == 0;
            twe = ($urandom % 40) == 0;
            tv  = 8'($urandom % 200);
            gie = 1'($urandom);
            line_req = 1'($urandom);
            vs  = 3'($urandom);
            word_sel = 2'($urandom);
            cyc(v, n, rd, twe, tv);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule